// File: doc/BRIEF.md
# Lowest-Priority Destination Arbiter

This block decides which of up to eight processor units an interrupt message is delivered to. A message gives an addressing mode (physical or logical), an 8-bit destination field and a delivery kind (fixed or lowest priority). Every unit continuously reports five things:

- whether it is present;
- its physical ID;
- its 8-bit logical ID mask;
- its task priority;
- the vector it is currently servicing (0 when idle).

For fixed delivery the block returns every matching unit as a bit vector. For lowest-priority delivery it returns exactly one matching unit. The winner is the unit whose effective priority is least. Effective priority is the larger of the upper nibble of its task priority and the upper nibble of its in-service vector.

A message is taken with a valid/ready handshake. The result is presented one cycle later on a registered valid/ready output. If no unit matches a message, the message is dropped and a one-cycle error pulse is raised instead of a result.

Top module: `lp_dest_arbiter`

## Requirements
- R1: After reset `out_valid` and `err_none` are 0 and `msg_ready` is 1.
- R2: In physical mode (`msg_logical`=0), unit slot i matches when its physical ID equals `msg_dest`.
- R3: In logical mode (`msg_logical`=1), unit slot i matches when its logical mask and `msg_dest` share at least one set bit.
- R4: In logical mode with `msg_dest`=8'hFF, every present unit matches, even one whose logical mask is zero.
- R5: For fixed delivery (`msg_lowest`=0), bit i of `out_targets` is set for each matching unit slot i, and no other bit is set.
- R6: For lowest-priority delivery (`msg_lowest`=1), `out_targets` has exactly one bit set: the matching slot with the least effective priority, max(task[7:4], in-service[7:4]).
- R7: The priority comparison uses upper nibbles only. Equal effective priorities are resolved toward the lowest physical ID, not the lowest slot index.
- R8: A message that matches no unit produces no output (`out_valid` stays 0), and `err_none` is 1 for exactly the one cycle after acceptance.
- R9: A message accepted at a clock edge appears on `out_valid`/`out_targets` right after that edge and not before. With `out_ready`=1, messages may be accepted on consecutive cycles.
- R10: While `out_valid`=1 and `out_ready`=0, the output holds stable and `msg_ready` is 0. Releasing `out_ready` retires the held result and accepts a waiting message in the same cycle.
- R11: A unit whose `unit_present` bit is 0 never matches, whatever its IDs or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Message can be taken this cycle |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_lowest | input | 1 | 1 = lowest-priority delivery, 0 = fixed |
| msg_dest | input | 8 | Destination field |
| unit_present | input | 8 | One bit per unit slot: unit exists |
| unit_phys_id | input | 64 | Physical ID per slot, slot i in bits [8i+7:8i] |
| unit_lmask | input | 64 | Logical ID mask per slot |
| unit_task_pri | input | 64 | Task priority per slot |
| unit_isr_vec | input | 64 | Highest in-service vector per slot, 0 if idle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_targets | output | 8 | Selected slots, one bit per slot |
| out_lowest | output | 1 | Result came from lowest-priority delivery |
| err_none | output | 1 | One-cycle pulse: last accepted message matched nobody |

## Verification
Two things can happen in the same clock cycle: a held result is retired, and a new message is accepted. The bench provokes this in two ways. First, it offers back-to-back messages with `out_ready` high. Second, it stalls `out_ready` with a second message waiting and then releases it. The output is judged at the following falling edge. It must show the second message's targets, with no cycle in which `out_valid` drops. A dropped message that follows a valid result in the next cycle is also checked. There, `out_valid` must fall and `err_none` must rise together.

// File: rtl/lpda_pkg.sv
// Shared sizing and the effective-priority helper for the destination arbiter.
// Assumes vectors and task priorities share one width, with the class in the top nibble.
package lpda_pkg;
    localparam int PRI_W = 4;

    // Larger of the two priority classes (upper nibbles) of task priority and in-service vector.
    function automatic logic [PRI_W-1:0] eff_class(input logic [PRI_W-1:0] task_cls,
                                                   input logic [PRI_W-1:0] isr_cls);
        return (task_cls > isr_cls) ? task_cls : isr_cls;
    endfunction
endpackage

// File: rtl/lpda_match.sv
// Per-unit destination matching.
// A slot matches on physical ID equality, on logical mask intersection, or on a logical
// all-ones broadcast. Absent slots never match. Purely combinational.
module lpda_match #(
    parameter int N_UNITS = 8,
    parameter int ID_W    = 8
) (
    input  logic                      logical_mode,
    input  logic [ID_W-1:0]           dest,
    input  logic [N_UNITS-1:0]        present,
    input  logic [N_UNITS*ID_W-1:0]   phys_id,
    input  logic [N_UNITS*ID_W-1:0]   lmask,
    output logic [N_UNITS-1:0]        elig
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic bcast_hit;
    // Detect the logical broadcast destination once for all slots.
    assign bcast_hit = (dest == BCAST);

    for (genvar i = 0; i < N_UNITS; i++) begin : g_slot
        logic phys_hit;
        logic log_hit;
        // Physical match: exact ID compare.
        assign phys_hit = (phys_id[i*ID_W +: ID_W] == dest);
        // Logical match: any shared bit, or broadcast.
        assign log_hit  = bcast_hit || (|(lmask[i*ID_W +: ID_W] & dest));
        // Combine by mode and gate with presence.
        assign elig[i]  = present[i] && (logical_mode ? log_hit : phys_hit);
    end
endmodule

// File: rtl/lpda_pick.sv
// Lowest-priority winner selection among the matching slots.
// Key = {effective class, physical ID}; the smallest key wins, so equal classes fall to
// the lowest physical ID. Output is one-hot, or zero when nothing matches. Combinational.
module lpda_pick
    import lpda_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int ID_W    = 8,
    parameter int VEC_W   = 8
) (
    input  logic [N_UNITS-1:0]        elig,
    input  logic [N_UNITS*ID_W-1:0]   phys_id,
    input  logic [N_UNITS*VEC_W-1:0]  task_pri,
    input  logic [N_UNITS*VEC_W-1:0]  isr_vec,
    output logic [N_UNITS-1:0]        onehot
);
    localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
    localparam int KEY_W = PRI_W + ID_W;

    logic [KEY_W-1:0] key [N_UNITS];
    logic             pri_unused;

    // The low nibbles carry no priority information.
    assign pri_unused = ^(task_pri ^ isr_vec);

    for (genvar i = 0; i < N_UNITS; i++) begin : g_key
        // Build the comparison key of slot i.
        assign key[i] = {eff_class(task_pri[i*VEC_W + VEC_W - 1 -: PRI_W],
                                   isr_vec[i*VEC_W + VEC_W - 1 -: PRI_W]),
                         phys_id[i*ID_W +: ID_W]};
    end

    // Linear minimum search over the matching slots.
    always_comb begin
        logic             found;
        logic [KEY_W-1:0] best_key;
        logic [IDX_W-1:0] best_idx;
        found    = 1'b0;
        best_key = '0;
        best_idx = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (elig[i] && (!found || key[i] < best_key)) begin
                found    = 1'b1;
                best_key = key[i];
                best_idx = IDX_W'(i);
            end
        end
        onehot = '0;
        if (found) onehot[best_idx] = 1'b1;
    end
endmodule

// File: rtl/lp_dest_arbiter.sv
// Top of the destination arbiter.
// Takes one message per handshake, and one cycle later registers either the fixed
// target set or the single lowest-priority winner. A message with no match is dropped
// with a one-cycle error pulse. Assumes the unit status inputs are stable while a
// message is offered.
module lp_dest_arbiter #(
    parameter int N_UNITS = 8,
    parameter int ID_W    = 8,
    parameter int VEC_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      msg_valid,
    output logic                      msg_ready,
    input  logic                      msg_logical,
    input  logic                      msg_lowest,
    input  logic [ID_W-1:0]           msg_dest,
    input  logic [N_UNITS-1:0]        unit_present,
    input  logic [N_UNITS*ID_W-1:0]   unit_phys_id,
    input  logic [N_UNITS*ID_W-1:0]   unit_lmask,
    input  logic [N_UNITS*VEC_W-1:0]  unit_task_pri,
    input  logic [N_UNITS*VEC_W-1:0]  unit_isr_vec,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [N_UNITS-1:0]        out_targets,
    output logic                      out_lowest,
    output logic                      err_none
);
    logic [N_UNITS-1:0] elig;
    logic [N_UNITS-1:0] winner;
    logic [N_UNITS-1:0] next_targets;
    logic               take;

    lpda_match #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_match (
        .logical_mode (msg_logical),
        .dest         (msg_dest),
        .present      (unit_present),
        .phys_id      (unit_phys_id),
        .lmask        (unit_lmask),
        .elig         (elig)
    );

    lpda_pick #(.N_UNITS(N_UNITS), .ID_W(ID_W), .VEC_W(VEC_W)) u_pick (
        .elig     (elig),
        .phys_id  (unit_phys_id),
        .task_pri (unit_task_pri),
        .isr_vec  (unit_isr_vec),
        .onehot   (winner)
    );

    // Accept when the output register is empty or is being drained.
    assign msg_ready    = !out_valid || out_ready;
    assign take         = msg_valid && msg_ready;
    // Choose the delivered set by delivery kind.
    assign next_targets = msg_lowest ? winner : elig;

    // Output register: load on acceptance, clear on drain, pulse error on no match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_targets <= '0;
            out_lowest  <= 1'b0;
            err_none    <= 1'b0;
        end else begin
            err_none <= 1'b0;
            if (take) begin
                out_valid   <= |elig;
                out_targets <= next_targets;
                out_lowest  <= msg_lowest;
                err_none    <= ~|elig;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lpda_checker.sv
// Protocol and result-shape properties for the destination arbiter, bound to the top.
module lpda_checker #(
    parameter int N_UNITS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [N_UNITS-1:0] out_targets,
    input logic               out_lowest,
    input logic               err_none
);
    // R6: a lowest-priority result names exactly one slot.
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_lowest) |-> ($countones(out_targets) == 1));

    // R5: a fixed result always names at least one slot.
    p_nonempty_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_targets != '0));

    // R8: an error pulse follows an acceptance and never coexists with a result.
    p_err_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_none |-> ($past(msg_valid && msg_ready) && !out_valid));

    // R10: a stalled result holds its value.
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_targets) && $stable(out_lowest)));

    // R10: no acceptance while stalled.
    p_no_take_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !msg_ready);
endmodule

bind lp_dest_arbiter lpda_checker #(.N_UNITS(N_UNITS)) u_lpda_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_targets (out_targets),
    .out_lowest  (out_lowest),
    .err_none    (err_none)
);

// File: tb/lp_dest_arbiter_bench.sv
`timescale 1ns/100ps
module lp_dest_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic        msg_logical = 1'b0;
    logic        msg_lowest = 1'b0;
    logic [7:0]  msg_dest = '0;
    logic [7:0]  unit_present;
    logic [63:0] unit_phys_id, unit_lmask, unit_task_pri, unit_isr_vec;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_targets;
    logic        out_lowest;
    logic        err_none;

    logic [7:0] pid [8];
    logic [7:0] lm  [8];
    logic [7:0] tp  [8];
    logic [7:0] iv  [8];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Pack the per-slot arrays onto the flat buses.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            unit_phys_id[i*8 +: 8]  = pid[i];
            unit_lmask[i*8 +: 8]    = lm[i];
            unit_task_pri[i*8 +: 8] = tp[i];
            unit_isr_vec[i*8 +: 8]  = iv[i];
        end
    end

    lp_dest_arbiter u_lp_dest_arbiter (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_logical(msg_logical), .msg_lowest(msg_lowest), .msg_dest(msg_dest),
        .unit_present(unit_present), .unit_phys_id(unit_phys_id), .unit_lmask(unit_lmask),
        .unit_task_pri(unit_task_pri), .unit_isr_vec(unit_isr_vec),
        .out_valid(out_valid), .out_ready(out_ready), .out_targets(out_targets),
        .out_lowest(out_lowest), .err_none(err_none)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Slot i: physical ID 7-i, logical mask one-hot on that ID, all present, task 0x20.
    task automatic cfg_default();
        for (int i = 0; i < 8; i++) begin
            pid[i] = 8'(7 - i);
            lm[i]  = 8'(1 << (7 - i));
            tp[i]  = 8'h20;
            iv[i]  = 8'h00;
        end
        unit_present = 8'hFF;
    endtask

    // Offer one message at a falling edge; sample the result at the next falling edge.
    task automatic send(input logic lg, input logic lo, input logic [7:0] d);
        @(negedge clk);
        msg_logical = lg; msg_lowest = lo; msg_dest = d; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 err_none", 32'(err_none), 0);
        chk("R1 msg_ready", 32'(msg_ready), 1);
    endtask

    task automatic t_physical();
        cfg_default();
        send(0, 0, 8'd3);
        chk("R2 valid", 32'(out_valid), 1);
        chk("R2 R5 targets phys 3", 32'(out_targets), 32'h10);
        send(0, 1, 8'd6);
        chk("R2 lowest phys 6", 32'(out_targets), 32'h02);
    endtask

    task automatic t_nomatch();
        cfg_default();
        send(0, 0, 8'd9);
        chk("R8 valid low", 32'(out_valid), 0);
        chk("R8 err pulse", 32'(err_none), 1);
        @(negedge clk);
        chk("R8 err one cycle", 32'(err_none), 0);
    endtask

    task automatic t_logical();
        cfg_default();
        send(1, 0, 8'h05);
        chk("R3 R5 mask 05", 32'(out_targets), 32'hA0);
        send(1, 0, 8'h00);
        chk("R3 empty dest err", 32'(err_none), 1);
    endtask

    task automatic t_broadcast();
        cfg_default();
        lm[2] = 8'h00;
        unit_present = 8'hFD;
        send(1, 0, 8'hFF);
        chk("R4 R11 broadcast", 32'(out_targets), 32'hFD);
    endtask

    task automatic t_lowest();
        cfg_default();
        for (int i = 0; i < 8; i++) tp[i] = 8'h50;
        tp[3] = 8'h3F;
        tp[6] = 8'h10; iv[6] = 8'h60;
        send(1, 1, 8'hFF);
        chk("R6 winner slot 3", 32'(out_targets), 32'h08);
        chk("R6 out_lowest", 32'(out_lowest), 1);
    endtask

    task automatic t_nibble_tie();
        cfg_default();
        for (int i = 0; i < 8; i++) tp[i] = 8'h50;
        tp[4] = 8'h4F;
        tp[1] = 8'h40;
        send(1, 1, 8'hFF);
        chk("R7 nibble tie low phys", 32'(out_targets), 32'h10);
    endtask

    task automatic t_absent();
        cfg_default();
        unit_present = 8'hFE;
        send(0, 1, 8'd7);
        chk("R11 absent phys err", 32'(err_none), 1);
        chk("R11 absent phys valid", 32'(out_valid), 0);
        cfg_default();
        for (int i = 0; i < 8; i++) tp[i] = 8'h50;
        tp[7] = 8'h00;
        unit_present = 8'h7F;
        send(1, 1, 8'hFF);
        chk("R11 R7 absent skipped", 32'(out_targets), 32'h40);
    endtask

    task automatic t_back_to_back();
        cfg_default();
        @(negedge clk);
        msg_logical = 0; msg_lowest = 0; msg_dest = 8'd0; msg_valid = 1;
        #1;
        chk("R9 not before edge", 32'(out_valid), 0);
        @(negedge clk);
        chk("R9 first", 32'(out_targets), 32'h80);
        msg_logical = 1; msg_dest = 8'h02;
        @(negedge clk);
        chk("R9 second valid", 32'(out_valid), 1);
        chk("R9 second", 32'(out_targets), 32'h40);
        msg_logical = 0; msg_dest = 8'd200;
        @(negedge clk);
        msg_valid = 0;
        chk("R9 R8 drop after result", 32'({out_valid, err_none}), 32'h1);
        @(negedge clk);
    endtask

    task automatic t_stall();
        cfg_default();
        out_ready = 0;
        send(0, 0, 8'd2);
        chk("R10 held valid", 32'(out_valid), 1);
        msg_dest = 8'd4; msg_valid = 1;
        #0.5;
        chk("R10 ready low", 32'(msg_ready), 0);
        repeat (2) @(negedge clk);
        chk("R10 held value", 32'(out_targets), 32'h20);
        out_ready = 1;
        @(negedge clk);
        msg_valid = 0;
        chk("R10 handover valid", 32'(out_valid), 1);
        chk("R10 handover value", 32'(out_targets), 32'h08);
        @(negedge clk);
        chk("R10 drained", 32'(out_valid), 0);
    endtask

    initial begin
        cfg_default();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_physical();
        t_nomatch();
        t_logical();
        t_broadcast();
        t_lowest();
        t_nibble_tie();
        t_absent();
        t_back_to_back();
        t_stall();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule